// File: doc/BRIEF.md
# Microcoded External Bus Timing Generator

This block produces the control waveforms of an external memory bus from microinstructions kept in a small writable store. A host loads 32-bit words through a simple write strobe. A start request then names the first word, the target bank and the transfer shape. The sequencer walks through consecutive words until it reaches one whose last-word flag is set. Each word covers one bus clock cycle.

The block runs on a clock four times faster than the bus clock. A 2-bit phase counter splits every bus cycle into quarters T1..T4, and T1 lines up with the rising bus clock edge. In each quarter, the chip select of the addressed bank and the byte selects of the lanes in use take the level that the word gives for that quarter. Six general-purpose lines hold one level for the whole bus cycle. Word layout: bits [31:28] are the chip-select levels for T1..T4 (bit 31 = T1), bits [27:24] are the byte-select levels for T1..T4 (bit 27 = T1), bits [23:18] are general-purpose lines 0..5 (bit 23 = line 0), bit 0 is the last-word flag, and the remaining bits are reserved.

Top module: `ucode_bus_timer`

## Requirements
- R1: After reset, every cs_no and bs_no line is high, gp_o is zero, phase_o is 0, and busy_o and done_o are low.
- R2: In quarter p (phase_o = p, 0 = T1) of a word, the cs_no line selected by bank_i equals word bit 31-p, so a 0 bit asserts it.
- R3: Every cs_no line other than the selected bank stays high throughout a sequence.
- R4: With size_i = 2'b00 (8-bit port), only lane addr_lo_i follows word bit 27-p in quarter p. The other bs_no lines stay high.
- R5: With size_i = 2'b01 (16-bit port), lanes 2*addr_lo_i[1] and 2*addr_lo_i[1]+1 follow word bit 27-p. The other two lanes stay high.
- R6: With size_i = 2'b10 (32-bit port), all four bs_no lines follow word bit 27-p.
- R7: For the whole of a word's four quarters, gp_o[k] equals word bit 23-k.
- R8: After a word without the last flag, the next word is taken from the next index, and index 63 wraps to 0. The first word comes from start_idx_i.
- R9: A word with bit 0 set is the last one. In the cycle after its fourth quarter, all outputs are inactive, busy_o is low and done_o is high, for exactly one cycle.
- R10: A start_i pulse while busy_o is high is ignored: the running sequence keeps its bank, lanes, word order and phase.
- R11: A write with wr_en_i stores wr_data_i at wr_addr_i, and later sequences use the new contents.
- R12: While busy, phase_o steps 0,1,2,3 once per clock. The first word's quarter 0 appears in the cycle after the clock edge that accepts start_i. phase_o is 0 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at four times the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Store write strobe |
| wr_addr_i | input | 6 | Store write index |
| wr_data_i | input | 32 | Microinstruction to store |
| start_i | input | 1 | Start request, taken only when idle |
| start_idx_i | input | 6 | Index of the first word |
| bank_i | input | 3 | Bank whose chip select is driven |
| size_i | input | 2 | Port width: 00 8-bit, 01 16-bit, 10 32-bit |
| addr_lo_i | input | 2 | Two low address bits for lane choice |
| cs_no | output | 8 | Chip selects, active low |
| bs_no | output | 4 | Byte-lane selects, active low |
| gp_o | output | 6 | General-purpose lines |
| phase_o | output | 2 | Current quarter, 0 = T1 |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the last word |

## Verification
The bench builds the block with its default parameters: 64 words, 8 banks and 4 lanes. This puts every bank, every port size and every low-address offset within reach of a full sweep of 96 sequences, and it makes a start at the top index exercise the wrap from 63 to 0. Expected pin levels for each quarter are derived arithmetically from a model of the store contents. The bench reloads the store with a second pattern to confirm that sequences use the new words. It also fires start requests in the middle of some sequences.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  localparam int WORD_W   = 32;
  localparam int CS_HI    = 31;
  localparam int BS_HI    = 27;
  localparam int GP_HI    = 23;
  localparam int GP_N     = 6;
  localparam int LAST_BIT = 0;
  localparam int PH_N     = 4;

  typedef enum logic [1:0] {
    SZ_8  = 2'b00,
    SZ_16 = 2'b01,
    SZ_32 = 2'b10
  } port_size_e;
endpackage

// File: rtl/ubt_store.sv
module ubt_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/ubt_lane_sel.sv
module ubt_lane_sel
  import ubt_pkg::*;
#(
  parameter int N_LANES = 4,
  localparam int LW     = $clog2(N_LANES)
) (
  input  logic [1:0]         size_i,
  input  logic [LW-1:0]      addr_lo_i,
  output logic [N_LANES-1:0] lane_mask_o
);
  int unsigned grp;
  logic [LW-1:0] base;

  always_comb begin
    unique case (port_size_e'(size_i))
      SZ_8:    grp = 1;
      SZ_16:   grp = 2;
      default: grp = N_LANES;
    endcase
    // align the low address down to the group size
    base        = addr_lo_i & LW'(~(grp - 1));
    lane_mask_o = N_LANES'(((1 << grp) - 1) << base);
  end
endmodule

// File: rtl/ubt_seq_ctrl.sv
module ubt_seq_ctrl
  import ubt_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int N_BANKS = 8,
  parameter int N_LANES = 4,
  localparam int AW     = $clog2(DEPTH),
  localparam int BW     = $clog2(N_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     start_idx_i,
  input  logic [BW-1:0]     bank_i,
  input  logic [N_LANES-1:0] lane_mask_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [AW-1:0]     rd_addr_o,
  output logic              run_o,
  output logic [1:0]        phase_o,
  output logic              done_o,
  output logic [BW-1:0]     bank_o,
  output logic [N_LANES-1:0] lanes_o,
  output logic [PH_N-1:0]   cs_f_o,
  output logic [PH_N-1:0]   bs_f_o,
  output logic [GP_N-1:0]   gp_f_o
);
  logic              run_q, done_q, last_q;
  logic [1:0]        phase_q;
  logic [AW-1:0]     ptr_q;
  logic [BW-1:0]     bank_q;
  logic [N_LANES-1:0] lanes_q;
  logic [PH_N-1:0]   cs_q, bs_q;
  logic [GP_N-1:0]   gp_q;
  logic              unused_rsvd;

  assign unused_rsvd = ^rd_data_i[GP_HI-GP_N:LAST_BIT+1];

  // idle: look at the requested start word; running: prefetch next word
  assign rd_addr_o = run_q ? ptr_q + AW'(1) : start_idx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      last_q  <= 1'b0;
      phase_q <= '0;
      ptr_q   <= '0;
      bank_q  <= '0;
      lanes_q <= '0;
      cs_q    <= '1;
      bs_q    <= '1;
      gp_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (start_i) begin
          run_q   <= 1'b1;
          phase_q <= '0;
          ptr_q   <= start_idx_i;
          bank_q  <= bank_i;
          lanes_q <= lane_mask_i;
          cs_q    <= rd_data_i[CS_HI -: PH_N];
          bs_q    <= rd_data_i[BS_HI -: PH_N];
          gp_q    <= rd_data_i[GP_HI -: GP_N];
          last_q  <= rd_data_i[LAST_BIT];
        end
      end else begin
        phase_q <= phase_q + 2'd1;
        if (phase_q == 2'd3) begin
          if (last_q) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            ptr_q  <= ptr_q + AW'(1);
            cs_q   <= rd_data_i[CS_HI -: PH_N];
            bs_q   <= rd_data_i[BS_HI -: PH_N];
            gp_q   <= rd_data_i[GP_HI -: GP_N];
            last_q <= rd_data_i[LAST_BIT];
          end
        end
      end
    end
  end

  assign run_o   = run_q;
  assign phase_o = phase_q;
  assign done_o  = done_q;
  assign bank_o  = bank_q;
  assign lanes_o = lanes_q;
  assign cs_f_o  = cs_q;
  assign bs_f_o  = bs_q;
  assign gp_f_o  = gp_q;
endmodule

// File: rtl/ubt_pin_drive.sv
module ubt_pin_drive
  import ubt_pkg::*;
#(
  parameter int N_BANKS = 8,
  parameter int N_LANES = 4,
  localparam int BW     = $clog2(N_BANKS)
) (
  input  logic               run_i,
  input  logic [1:0]         phase_i,
  input  logic [BW-1:0]      bank_i,
  input  logic [N_LANES-1:0] lanes_i,
  input  logic [PH_N-1:0]    cs_f_i,
  input  logic [PH_N-1:0]    bs_f_i,
  input  logic [GP_N-1:0]    gp_f_i,
  output logic [N_BANKS-1:0] cs_no,
  output logic [N_LANES-1:0] bs_no,
  output logic [GP_N-1:0]    gp_o
);
  logic cs_lvl, bs_lvl;

  // field MSB is T1, so quarter p reads bit (3 - p)
  assign cs_lvl = cs_f_i[~phase_i];
  assign bs_lvl = bs_f_i[~phase_i];

  for (genvar b = 0; b < N_BANKS; b++) begin : g_cs
    assign cs_no[b] = !(run_i && bank_i == BW'(b)) || cs_lvl;
  end

  for (genvar l = 0; l < N_LANES; l++) begin : g_bs
    assign bs_no[l] = !(run_i && lanes_i[l]) || bs_lvl;
  end

  for (genvar k = 0; k < GP_N; k++) begin : g_gp
    assign gp_o[k] = run_i && gp_f_i[GP_N-1-k];
  end
endmodule

// File: rtl/ucode_bus_timer.sv
module ucode_bus_timer
  import ubt_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int N_BANKS = 8,
  parameter int N_LANES = 4,
  localparam int AW     = $clog2(DEPTH),
  localparam int BW     = $clog2(N_BANKS),
  localparam int LW     = $clog2(N_LANES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic               start_i,
  input  logic [AW-1:0]      start_idx_i,
  input  logic [BW-1:0]      bank_i,
  input  logic [1:0]         size_i,
  input  logic [LW-1:0]      addr_lo_i,
  output logic [N_BANKS-1:0] cs_no,
  output logic [N_LANES-1:0] bs_no,
  output logic [GP_N-1:0]    gp_o,
  output logic [1:0]         phase_o,
  output logic               busy_o,
  output logic               done_o
);
  logic [AW-1:0]      rd_addr;
  logic [WORD_W-1:0]  rd_data;
  logic [N_LANES-1:0] lane_mask, lanes;
  logic [BW-1:0]      bank;
  logic [PH_N-1:0]    cs_f, bs_f;
  logic [GP_N-1:0]    gp_f;
  logic               run;
  logic [1:0]         phase;

  ubt_store #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  ubt_lane_sel #(.N_LANES(N_LANES)) u_lane (
    .size_i      (size_i),
    .addr_lo_i   (addr_lo_i),
    .lane_mask_o (lane_mask)
  );

  ubt_seq_ctrl #(.DEPTH(DEPTH), .N_BANKS(N_BANKS), .N_LANES(N_LANES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_idx_i (start_idx_i),
    .bank_i      (bank_i),
    .lane_mask_i (lane_mask),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .run_o       (run),
    .phase_o     (phase),
    .done_o      (done_o),
    .bank_o      (bank),
    .lanes_o     (lanes),
    .cs_f_o      (cs_f),
    .bs_f_o      (bs_f),
    .gp_f_o      (gp_f)
  );

  ubt_pin_drive #(.N_BANKS(N_BANKS), .N_LANES(N_LANES)) u_pins (
    .run_i   (run),
    .phase_i (phase),
    .bank_i  (bank),
    .lanes_i (lanes),
    .cs_f_i  (cs_f),
    .bs_f_i  (bs_f),
    .gp_f_i  (gp_f),
    .cs_no   (cs_no),
    .bs_no   (bs_no),
    .gp_o    (gp_o)
  );

  assign busy_o  = run;
  assign phase_o = phase;
endmodule

// File: rtl/ucode_bus_timer_chk.sv
module ucode_bus_timer_chk #(
  parameter int N_BANKS = 8,
  parameter int N_LANES = 4,
  parameter int N_GP    = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [N_BANKS-1:0] cs_no,
  input logic [N_LANES-1:0] bs_no,
  input logic [N_GP-1:0]    gp_o,
  input logic [1:0]         phase_o,
  input logic               busy_o,
  input logic               done_o
);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (&cs_no && &bs_no && gp_o == '0));

  p_one_bank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  p_phase_step_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && phase_o != 2'd3) |=> (busy_o && phase_o == $past(phase_o) + 2'd1));

  p_idle_phase_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> phase_o == 2'd0);

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && phase_o == 2'd3 |=> (done_o == !busy_o));

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && phase_o != 2'd3) |=> (busy_o && phase_o == $past(phase_o) + 2'd1));
endmodule

bind ucode_bus_timer ucode_bus_timer_chk #(
  .N_BANKS(N_BANKS), .N_LANES(N_LANES), .N_GP(ubt_pkg::GP_N)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .cs_no   (cs_no),
  .bs_no   (bs_no),
  .gp_o    (gp_o),
  .phase_o (phase_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/ucode_bus_timer_test.sv
`timescale 1ns/1ps
module ucode_bus_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        start = 1'b0;
  logic [5:0]  start_idx = '0;
  logic [2:0]  bank = '0;
  logic [1:0]  size = '0;
  logic [1:0]  addr_lo = '0;
  logic [7:0]  cs_n;
  logic [3:0]  bs_n;
  logic [5:0]  gp;
  logic [1:0]  phase;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [64];

  always #2 clk = ~clk;

  ucode_bus_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .start_i(start), .start_idx_i(start_idx),
    .bank_i(bank), .size_i(size), .addr_lo_i(addr_lo),
    .cs_no(cs_n), .bs_no(bs_n), .gp_o(gp), .phase_o(phase),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(int i, int seed);
    int cs = (i * 7 + seed * 3 + 1) % 16;
    int bs = (i * 11 + seed * 5 + 6) % 16;
    int g  = (i * 13 + seed * 17 + 9) % 64;
    return {4'(cs), 4'(bs), 6'(g), 17'd0, 1'((i % 3) == 2)};
  endfunction

  task automatic load(int seed);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 6'(i);
      wr_data = pattern(i, seed);
      model[i] = wr_data;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_seq(int st, int bk, int sz, int al, bit poke, string tag);
    int len = 1;
    int idx = st;
    logic [3:0] mask;
    while (model[idx][0] == 1'b0) begin
      idx = (idx + 1) % 64;
      len++;
    end
    case (sz)
      0: mask = 4'(1 << al);
      1: mask = 4'(3 << (al & 2));
      default: mask = 4'hF;
    endcase
    @(negedge clk);
    start = 1'b1; start_idx = 6'(st); bank = 3'(bk); size = 2'(sz); addr_lo = 2'(al);
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < len; w++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] word = model[(st + w) % 64];
        logic [7:0] ecs = 8'hFF;
        logic [3:0] ebs = 4'hF;
        logic [5:0] egp;
        int n = w * 4 + p;
        ecs[bk] = word[31-p];
        for (int l = 0; l < 4; l++) if (mask[l]) ebs[l] = word[27-p];
        for (int k = 0; k < 6; k++) egp[k] = word[23-k];
        // R2 R3 R8: bank line follows the current word in order
        chk({tag, " R2 R3 R8 cs"}, 32'(cs_n), 32'(ecs));
        case (sz)
          0: chk({tag, " R4 bs"}, 32'(bs_n), 32'(ebs));
          1: chk({tag, " R5 bs"}, 32'(bs_n), 32'(ebs));
          default: chk({tag, " R6 bs"}, 32'(bs_n), 32'(ebs));
        endcase
        chk({tag, " R7 gp"}, 32'(gp), 32'(egp));
        chk({tag, " R12 busy/phase/done"}, {29'd0, busy, phase}, {29'd0, 1'b1, 2'(p)});
        if (done) chk({tag, " R9 early done"}, 32'(done), 32'd0);
        if (poke && n == 1) begin  // R10: disturbing start mid-run
          start = 1'b1; start_idx = 6'(st + 5); bank = 3'(bk + 1); size = 2'((sz + 1) % 3);
        end
        if (poke && n == 2) start = 1'b0;
        @(negedge clk);
      end
    end
    chk({tag, " R9 end state"}, {cs_n, bs_n, gp, busy, done, phase},
        {8'hFF, 4'hF, 6'd0, 1'b0, 1'b1, 2'd0});
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (20000 * 10) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 reset", {cs_n, bs_n, gp, busy, done, phase},
        {8'hFF, 4'hF, 6'd0, 1'b0, 1'b0, 2'd0});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {cs_n, bs_n, gp, busy, done, phase},
        {8'hFF, 4'hF, 6'd0, 1'b0, 1'b0, 2'd0});
    load(0);
    for (int b = 0; b < 8; b++)
      for (int s = 0; s < 3; s++)
        for (int a = 0; a < 4; a++) begin
          int r = b * 12 + s * 4 + a;
          run_seq((r * 13 + 5) % 64, b, s, a, (r % 5) == 0, (r % 5) == 0 ? "R10" : "sweep");
        end
    // R8: wrap from the top index
    run_seq(63, 2, 2, 0, 1'b0, "R8 wrap");
    run_seq(62, 7, 0, 3, 1'b0, "R8 single");
    // R11: new contents take effect
    load(1);
    for (int i = 0; i < 8; i++) run_seq(i * 9 % 64, i, i % 3, (i * 3) % 4, 1'b0, "R11 reload");
    run_seq(63, 5, 1, 2, 1'b1, "R11 wrap");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule